// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block is a word-addressed register bank for system configuration values. It sits in a 4 KB window on a simple 32-bit bus with a write strobe, an address and write data. It returns read data either in the same cycle or one cycle later, as a parameter selects. A protection latch guards every register from offset 0x100 upward. Software opens the latch by writing a 16-bit opening key to one control word and closes it again by writing a different 16-bit closing key to another. A status word reports whether the latch is closed.

A few words below 0x100 stay usable whatever the latch state. One of them is a single-bit scratch flag. Inside the guarded area, some offsets are read-only words with fixed contents, one is a constant, and one is a gap that always reads zero. The stored values drive nothing outside the bank. Every access is a full aligned word.

Top module: `cfgbank_top`

## Requirements
- R1: After reset the latch is closed: reading offset 0xC returns 0x00000001 and reading offset 0x0 returns 0x00000000.
- R2: A write to offset 0x8 opens the latch only when wdata[15:0] equals 0xDF0D. wdata[31:16] is ignored, and any other low half leaves the latch as it was.
- R3: A write to offset 0x4 closes the latch only when wdata[15:0] equals 0x767B. Any other low half leaves the latch as it was.
- R4: Offset 0xC reads the latch state in bit 0 (1 = closed) with bits 31:1 zero, and writes to it change nothing. Offsets 0x4 and 0x8 always read 0.
- R5: Offset 0x0 stores wdata[0] on every write, whether the latch is open or closed. It reads that bit in bit 0, with bits 31:1 zero.
- R6: While the latch is closed, a write to any offset from 0x100 upward leaves every register unchanged.
- R7: While the latch is open, a write to one of the writable words (0x100, 0x104, 0x108, 0x110, 0x120, 0x124, 0x200, 0x300, 0x600, 0xB00) stores all 32 bits of the write data.
- R8: The words 0x10C, 0x250, 0x910, 0xB20 and 0xB2C can be read but keep their reset contents through any write, even with the latch open. Offset 0x604 always reads 0.
- R9: Offset 0x25C always reads 0x00000001.
- R10: Reset contents: 0x100, 0x104 and 0x108 hold 0x0001A008; 0x10C holds 0x0000003F; 0x110 holds 0x00014000; 0x120 holds 0x1F000400; 0x124 holds 0x18400003. Every other register word resets to 0.
- R11: An offset that maps to no register reads 0, and writes to it change no register.
- R12: With RD_LAT = 0, rdata shows the word at the current address in the same cycle. With RD_LAT = 1, rdata shows the word at the address presented in the previous cycle.
- R13: A write takes effect at the clock edge where wr_en is high, so a read issued in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for one word |
| addr | input | ADDR_W (12) | Byte offset of the word; bits 1:0 are zero |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, with a latency set by RD_LAT |

## Verification
Every cycle, the assertions check how the latch reacts to each key word: the correct key forces the new state, and any cycle without a key write leaves the state unchanged. They also check that the whole register array is frozen after any write while the latch is closed, that the scratch bit follows the data written, and that the key words and the constant word read their fixed values at the configured latency. The bench's scenarios are needed for everything else. That covers the reset contents of every word, full-window sweeps showing which offsets accept data and which discard it, the rejected near-miss keys, and the read latency seen from the ports.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int OFF_W = 12;
  localparam int REG_W = 32;
  localparam int KEY_W = 16;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;

  localparam logic [OFF_W-1:0] A_SCRATCH = 12'h000;
  localparam logic [OFF_W-1:0] A_CLOSE   = 12'h004;
  localparam logic [OFF_W-1:0] A_OPEN    = 12'h008;
  localparam logic [OFF_W-1:0] A_STATUS  = 12'h00C;
  localparam logic [OFF_W-1:0] A_ONE     = 12'h25C;

  localparam int NUM_CFG = 15;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    logic [REG_W-1:0] rst;
    logic             wr;
  } cfg_slot_t;

  // Descriptor of each stored word: offset, reset contents, writability.
  function automatic cfg_slot_t cfg_slot(input int idx);
    cfg_slot_t s;
    case (idx)
      0:       s = '{off: 12'h100, rst: 32'h0001A008, wr: 1'b1};
      1:       s = '{off: 12'h104, rst: 32'h0001A008, wr: 1'b1};
      2:       s = '{off: 12'h108, rst: 32'h0001A008, wr: 1'b1};
      3:       s = '{off: 12'h10C, rst: 32'h0000003F, wr: 1'b0};
      4:       s = '{off: 12'h110, rst: 32'h00014000, wr: 1'b1};
      5:       s = '{off: 12'h120, rst: 32'h1F000400, wr: 1'b1};
      6:       s = '{off: 12'h124, rst: 32'h18400003, wr: 1'b1};
      7:       s = '{off: 12'h200, rst: 32'h00000000, wr: 1'b1};
      8:       s = '{off: 12'h250, rst: 32'h00000000, wr: 1'b0};
      9:       s = '{off: 12'h300, rst: 32'h00000000, wr: 1'b1};
      10:      s = '{off: 12'h600, rst: 32'h00000000, wr: 1'b1};
      11:      s = '{off: 12'h910, rst: 32'h00000000, wr: 1'b0};
      12:      s = '{off: 12'hB00, rst: 32'h00000000, wr: 1'b1};
      13:      s = '{off: 12'hB20, rst: 32'h00000000, wr: 1'b0};
      14:      s = '{off: 12'hB2C, rst: 32'h00000000, wr: 1'b0};
      default: s = '{off: 12'hFFC, rst: 32'h00000000, wr: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cfgbank_rst_sync.sv
module cfgbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfgbank_lock.sv
module cfgbank_lock
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEY_W-1:0]  key_data,
  output logic              locked,
  output logic              scratch
);

  logic open_hit;
  logic close_hit;
  logic lock_en;
  logic lock_d;
  logic lock_q;
  logic scr_en;
  logic scr_d;
  logic scr_q;

  always_comb begin
    open_hit  = wr_en && (addr == ADDR_W'(A_OPEN))  && (key_data == KEY_OPEN);
    close_hit = wr_en && (addr == ADDR_W'(A_CLOSE)) && (key_data == KEY_CLOSE);
    lock_en   = open_hit || close_hit;
    lock_d    = close_hit;
    scr_en    = wr_en && (addr == ADDR_W'(A_SCRATCH));
    scr_d     = key_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q <= 1'b0;
    end else if (scr_en) begin
      scr_q <= scr_d;
    end
  end

  assign locked  = lock_q;
  assign scratch = scr_q;

endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = OFF_W,
  parameter int DATA_W = REG_W,
  parameter int NREG   = NUM_CFG
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   locked,
  output logic [DATA_W-1:0]      rd_val,
  output logic                   rd_hit,
  output logic [NREG*DATA_W-1:0] vals_flat
);

  logic [NREG-1:0]             sel;
  logic [NREG-1:0][DATA_W-1:0] val;
  logic                        wr_ok;

  assign wr_ok = wr_en & ~locked;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam cfg_slot_t          SLOT      = cfg_slot(i);
    localparam logic [ADDR_W-1:0]  SLOT_ADDR = ADDR_W'(SLOT.off);
    localparam logic [DATA_W-1:0]  SLOT_RST  = DATA_W'(SLOT.rst);

    assign sel[i] = (addr == SLOT_ADDR);

    if (SLOT.wr) begin : g_rw
      logic              en;
      logic [DATA_W-1:0] d;
      logic [DATA_W-1:0] q;

      always_comb begin
        en = wr_ok & sel[i];
        d  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= SLOT_RST;
        end else if (en) begin
          q <= d;
        end
      end

      assign val[i] = q;
    end else begin : g_ro
      assign val[i] = SLOT_RST;
    end

    assign vals_flat[i*DATA_W +: DATA_W] = val[i];
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++) begin
      if (sel[k]) begin
        rd_val = rd_val | val[k];
      end
    end
    rd_hit = |sel;
  end

endmodule

// File: rtl/cfgbank_rdpath.sv
module cfgbank_rdpath
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = OFF_W,
  parameter int DATA_W = REG_W,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  input  logic              scratch,
  input  logic [DATA_W-1:0] bank_val,
  input  logic              bank_hit,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    if (addr == ADDR_W'(A_SCRATCH)) begin
      mux_d = DATA_W'(scratch);
    end else if (addr == ADDR_W'(A_STATUS)) begin
      mux_d = DATA_W'(locked);
    end else if ((addr == ADDR_W'(A_CLOSE)) || (addr == ADDR_W'(A_OPEN))) begin
      mux_d = '0;
    end else if (addr == ADDR_W'(A_ONE)) begin
      mux_d = DATA_W'(1);
    end else if (bank_hit) begin
      mux_d = bank_val;
    end else begin
      mux_d = '0;
    end
  end

  if (RD_LAT == 0) begin : g_comb
    assign rdata = mux_d;
  end else begin : g_reg
    logic [DATA_W-1:0] rd_q;
    logic              rd_en;

    assign rd_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else if (rd_en) begin
        rd_q <= mux_d;
      end
    end

    assign rdata = rd_q;
  end

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int ADDR_W = OFF_W,
  parameter int DATA_W = REG_W,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int NREG   = NUM_CFG;
  localparam int FLAT_W = NREG * DATA_W;

  logic              rst_sync_n;
  logic              locked;
  logic              scratch_bit;
  logic [DATA_W-1:0] bank_val;
  logic              bank_hit;
  logic [FLAT_W-1:0] bank_vals;

  cfgbank_rst_sync #(
    .STAGES(2)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cfgbank_lock #(
    .ADDR_W(ADDR_W)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .key_data(wdata[KEY_W-1:0]),
    .locked  (locked),
    .scratch (scratch_bit)
  );

  cfgbank_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NREG  (NREG)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .locked   (locked),
    .rd_val   (bank_val),
    .rd_hit   (bank_hit),
    .vals_flat(bank_vals)
  );

  cfgbank_rdpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .RD_LAT(RD_LAT)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (addr),
    .locked  (locked),
    .scratch (scratch_bit),
    .bank_val(bank_val),
    .bank_hit(bank_hit),
    .rdata   (rdata)
  );

endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int RD_LAT = 1,
  parameter int FLAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              locked,
  input logic              scratch,
  input logic [FLAT_W-1:0] bank_vals
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] eff_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '1;
    end else begin
      addr_q <= addr;
    end
  end

  assign eff_addr = (RD_LAT != 0) ? addr_q : addr;

  AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> locked); // R1

  AST_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h008) && wdata[15:0] == 16'hDF0D) |=> !locked); // R2

  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h004) && wdata[15:0] == 16'h767B) |=> locked); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADDR_W'(12'h004) || addr == ADDR_W'(12'h008))) |=> $stable(locked)); // R4

  AST_KEYWORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_addr == ADDR_W'(12'h004) || eff_addr == ADDR_W'(12'h008)) |-> rdata == '0); // R4

  AST_SCRATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h000)) |=> scratch == $past(wdata[0])); // R5

  AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en) |=> $stable(bank_vals)); // R6

  AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_addr == ADDR_W'(12'h25C)) |-> rdata == DATA_W'(1)); // R9

endmodule

bind cfgbank_top cfgbank_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .RD_LAT(RD_LAT),
  .FLAT_W(FLAT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .locked   (locked),
  .scratch  (scratch_bit),
  .bank_vals(bank_vals)
);

// File: tb/tb_cfgbank_top.sv
module tb_cfgbank_top;

  localparam int LAT = 1;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic [31:0] mem [WORDS];
  logic        m_lock;
  logic        m_scr;

  always #2 clk = ~clk;

  cfgbank_top #(.RD_LAT(LAT)) dut (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata)
  );

  function automatic logic [31:0] rst_of(input int o);
    case (o)
      'h100, 'h104, 'h108: return 32'h0001A008;
      'h10C:               return 32'h0000003F;
      'h110:               return 32'h00014000;
      'h120:               return 32'h1F000400;
      'h124:               return 32'h18400003;
      default:             return 32'h0;
    endcase
  endfunction

  function automatic bit is_rw(input int o);
    return o inside {'h100, 'h104, 'h108, 'h110, 'h120, 'h124,
                     'h200, 'h300, 'h600, 'hB00};
  endfunction

  function automatic bit is_fixed(input int o);
    return o inside {'h10C, 'h250, 'h910, 'hB20, 'hB2C};
  endfunction

  function automatic logic [31:0] exp_rd(input int o);
    if (o == 'h0)                return {31'b0, m_scr};
    if (o == 'h4 || o == 'h8)    return 32'h0;
    if (o == 'hC)                return {31'b0, m_lock};
    if (o == 'h25C)              return 32'h1;
    if (is_rw(o) || is_fixed(o)) return mem[o >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(input int o);
    if (o == 'h0)                          return "R5";
    if (o == 'h4 || o == 'h8 || o == 'hC)  return "R4";
    if (o == 'h25C)                        return "R9";
    if (is_fixed(o) || o == 'h604)         return "R8";
    if (is_rw(o))                          return "R7";
    return "R11";
  endfunction

  task automatic chk(input string req, input int o,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s offset 0x%03h actual 0x%08h expected 0x%08h",
               req, o, act, exp);
    end
  endtask

  task automatic wr(input int o, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = o[11:0];
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (o == 'h0) m_scr = d[0];
    else if (o == 'h4 && d[15:0] == 16'h767B) m_lock = 1'b1;
    else if (o == 'h8 && d[15:0] == 16'hDF0D) m_lock = 1'b0;
    else if (!m_lock && is_rw(o)) mem[o >> 2] = d;
  endtask

  task automatic rd(input int o, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = o[11:0];
    if (LAT != 0) @(negedge clk);
    else #1;
    v = rdata;
  endtask

  task automatic sweep(input string req_over);
    logic [31:0] v;
    for (int o = 0; o < WORDS * 4; o += 4) begin
      rd(o, v);
      chk((req_over != "") ? req_over : tag_of(o), o, v, exp_rd(o));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    m_lock = 1'b1;
    m_scr  = 1'b0;
    for (int o = 0; o < WORDS * 4; o += 4) mem[o >> 2] = rst_of(o);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: latch closed, scratch clear after reset
    rd('hC, v); chk("R1", 'hC, v, 32'h1);
    rd('h0, v); chk("R1", 'h0, v, 32'h0);

    // R10: reset contents across the whole window
    sweep("");
    for (int o = 'h100; o < 'h200; o += 4) begin
      rd(o, v); chk("R10", o, v, rst_of(o));
    end

    // R6: closed latch discards every bank write
    for (int o = 'h100; o < WORDS * 4; o += 4)
      wr(o, {4'hC, o[11:0], ~o[15:0]});
    sweep("R6");

    // R4: status word ignores writes
    wr('hC, 32'h0); rd('hC, v); chk("R4", 'hC, v, 32'h1);

    // R2: near-miss keys rejected, upper bits ignored
    wr('h8, 32'h0000DF0C); rd('hC, v); chk("R2", 'hC, v, 32'h1);
    wr('h4, 32'h0000DF0D); rd('hC, v); chk("R2", 'hC, v, 32'h1);
    wr('h8, 32'hFFFFDF0D); rd('hC, v); chk("R2", 'hC, v, 32'h0);

    // R13: new value visible on the next read
    wr('h300, 32'h12345678); rd('h300, v); chk("R13", 'h300, v, 32'h12345678);

    // R7 / R8 / R11: open-latch write sweep, then read back
    for (int o = 'h100; o < WORDS * 4; o += 4)
      wr(o, {o[11:0], 4'h5, ~o[15:0]});
    sweep("");
    rd('h604, v); chk("R8", 'h604, v, 32'h0);

    // R3: near-miss close key, then the real one
    wr('h4, 32'h0000767A); rd('hC, v); chk("R3", 'hC, v, 32'h0);
    wr('h8, 32'h0000767B); rd('hC, v); chk("R3", 'hC, v, 32'h0);
    wr('h4, 32'hABCD767B); rd('hC, v); chk("R3", 'hC, v, 32'h1);
    wr('h120, 32'hDEADBEEF); rd('h120, v); chk("R6", 'h120, v, exp_rd('h120));

    // R5: scratch writable while closed, only bit 0 kept
    wr('h0, 32'hFFFFFFFF); rd('h0, v); chk("R5", 'h0, v, 32'h1);
    wr('h0, 32'hFFFFFFFE); rd('h0, v); chk("R5", 'h0, v, 32'h0);
    rd('h4, v); chk("R4", 'h4, v, 32'h0);
    rd('h8, v); chk("R4", 'h8, v, 32'h0);

    // R12: read latency seen at the port
    @(negedge clk);
    addr = 12'h25C;
    @(negedge clk);
    addr = 12'h0C;
    #1;
    if (LAT != 0) chk("R12", 'h25C, rdata, 32'h1);
    else          chk("R12", 'hC, rdata, 32'h1);
    @(negedge clk);
    addr = 12'h104;
    #1;
    if (LAT != 0) chk("R12", 'hC, rdata, 32'h1);
    else          chk("R12", 'h104, rdata, exp_rd('h104));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule